// File: doc/BRIEF.md
# Charge Cycle Sequencer

This block is the digital sequencer of a linear single-cell lithium-ion charger. It reads comparator and loop-status flags from the analog side: input valid, battery below the low-voltage threshold, constant-voltage control dominant, and current at the termination level. It also reads the active limiting loops (input-voltage limit, power-path limit, thermal limit) and the warm and cool temperature zones.

From these flags it decides whether the cell is off, pre-charging, fast-charging, finished or faulted. It selects the current setpoint for the analog current loop and drives the charge-FET enable. It also runs a safety timer that can slow to half rate while a limiting loop holds the current down.

Two inputs gate charging. One is an active-high inhibit pin and the other is an inhibit register bit. Whenever the applied setpoint has to change, the FET is first switched off for a fixed gap so the new value is never applied under load. All timing comes from the system clock through parameterised prescaler and gap counts.

Top module: `chg_cycle_ctrl`

## Requirements
- R1: Charging runs only when both `hold_pin` and `inhibit_bit` are 0. If either is 1 in any state other than fault, the state is off (code 0) after the next clock.
- R2: From off with a valid input and charging allowed, the state becomes pre-charge (code 1) after one clock if `bat_low` is 1, and fast charge (code 2) otherwise. Pre-charge moves to fast charge one clock after `bat_low` falls.
- R3: The target setpoint depends on the state:
  - In pre-charge it is `ipre_code`.
  - In fast charge it is `ifast_code`, shifted right by one bit while `zone_warm` or `zone_cool` is 1.
  - Outside those two states the applied setpoint `iset_o` is 0.
- R4: A target that differs from the applied setpoint turns `fet_on_o` off at once. The applied value is then updated `GAP_CYC` clocks later to the target present at that moment, and the FET stays off until then. This covers a code write, the pre-charge to fast-charge move and a zone change.
- R5: Fast charge ends in done (code 3) only when all of these hold:
  - `at_iterm` and `cv_dom` are both 1;
  - `lim_vin`, `lim_path`, `lim_therm` and `zone_warm` are all 0.
- R6: In done the FET is off, and the state holds while the input is valid and charging is allowed.
- R7: The safety timer counts one tick every `PRESC_DIV` clocks while charging.
  - The fast-charge limit is `TMR_BASE << tmr_sel` ticks, and the pre-charge limit is a quarter of it.
  - Reaching the limit enters fault (code 4): `tmr_fault_o` goes to 1 and the FET turns off.
- R8: With `tmr_x2` set, the timer advances on every second tick while any of `lim_vin`, `lim_path`, `lim_therm`, `zone_warm` or `zone_cool` is 1.
- R9: A change of `tmr_sel` while charging restarts the timer from zero.
- R10: Fault holds while `hold_pin` is 0 and the input is valid, whatever `inhibit_bit` is. Raising `hold_pin` or losing the input returns to off.
- R11: When `vin_ok` is 0 the state is off after the next clock, and the timer and setpoint are cleared.
- R12: After reset the state is off, `iset_o` is 0, and `fet_on_o` and `tmr_fault_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_ok | input | 1 | Input supply within its valid window |
| hold_pin | input | 1 | Inhibit pin, 1 blocks charging |
| inhibit_bit | input | 1 | Inhibit register bit, 1 blocks charging |
| bat_low | input | 1 | Battery below low-voltage threshold |
| cv_dom | input | 1 | Constant-voltage loop dominant |
| at_iterm | input | 1 | Charge current at termination level |
| lim_vin | input | 1 | Input-voltage limit loop active |
| lim_path | input | 1 | Power-path limit loop active |
| lim_therm | input | 1 | Thermal loop active |
| zone_warm | input | 1 | Battery in warm zone |
| zone_cool | input | 1 | Battery in cool zone |
| ifast_code | input | ICODE_W | Programmed fast-charge current code |
| ipre_code | input | ICODE_W | Programmed pre-charge current code |
| tmr_sel | input | 2 | Safety-timer duration select |
| tmr_x2 | input | 1 | Half-rate timer option |
| state_o | output | 3 | State code: 0 off, 1 pre, 2 fast, 3 done, 4 fault |
| iset_o | output | ICODE_W | Applied current setpoint |
| fet_on_o | output | 1 | Charge-FET enable |
| tmr_fault_o | output | 1 | Safety-timer fault |

## Verification
Most internal errors reach the ports within one clock. A wrong state register, a wrong gap count or a mismatched applied setpoint each show up on the next compare of `state_o`, `fet_on_o` or `iset_o`. A wrong safety-timer count stays hidden until its limit is reached, and then appears as a fault entry that is early or late by whole prescaler periods. The timer scenarios therefore run to expiry with and without half-rate and restart, so that such a drift becomes visible.

// File: rtl/chg_pkg.sv
`timescale 1ns/1ps
package chg_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_PRE   = 3'd1,
        ST_FAST  = 3'd2,
        ST_DONE  = 3'd3,
        ST_FAULT = 3'd4
    } chg_state_e;

    typedef struct packed {
        chg_state_e state;
    } fsm_regs_t;

    function automatic logic is_charging(chg_state_e s);
        return (s == ST_PRE) || (s == ST_FAST);
    endfunction

endpackage

// File: rtl/chg_safety_timer.sv
`timescale 1ns/1ps
module chg_safety_timer #(
    parameter int PRESC_DIV = 250000,
    parameter int TMR_BASE  = 3600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       slow,
    input  logic [1:0] sel,
    output logic       pre_exp,
    output logic       fast_exp
);
    localparam int FAST_MAX = TMR_BASE * 8;
    localparam int CNT_W    = $clog2(FAST_MAX + 1);
    localparam int PS_W     = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;

    typedef struct packed {
        logic [PS_W-1:0]  presc;
        logic [CNT_W-1:0] cnt;
        logic             half;
        logic [1:0]       sel;
    } tmr_regs_t;

    tmr_regs_t r_q, r_d;
    logic tick;
    logic [CNT_W-1:0] fast_lim, pre_lim;

    generate
        if (PRESC_DIV == 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            assign tick = (r_q.presc == PS_W'(PRESC_DIV - 1));
        end
    endgenerate

    always_comb begin
        fast_lim = CNT_W'(TMR_BASE) << sel;
        pre_lim  = fast_lim >> 2;
        pre_exp  = (r_q.cnt >= pre_lim);
        fast_exp = (r_q.cnt >= fast_lim);
    end

    // R7 R8 R9: prescaled count, half-rate toggle, restart on duration change
    always_comb begin
        r_d     = r_q;
        r_d.sel = sel;
        if (!run || (sel != r_q.sel)) begin
            r_d.presc = '0;
            r_d.cnt   = '0;
            r_d.half  = 1'b0;
        end else if (tick) begin
            r_d.presc = '0;
            if (slow) begin
                r_d.half = ~r_q.half;
            end
            if (!slow || r_q.half) begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end else begin
            r_d.presc = r_q.presc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/chg_setpoint_gap.sv
`timescale 1ns/1ps
module chg_setpoint_gap #(
    parameter int ICODE_W = 8,
    parameter int GAP_CYC = 250000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic [ICODE_W-1:0] target,
    output logic [ICODE_W-1:0] iset,
    output logic               fet_ok
);
    localparam int GW = $clog2(GAP_CYC + 1);

    typedef struct packed {
        logic [ICODE_W-1:0] iset;
        logic [GW-1:0]      gap;
    } gap_regs_t;

    gap_regs_t r_q, r_d;

    // R4: mismatch opens a gap; the value present at its end is applied
    always_comb begin
        r_d = r_q;
        if (!active) begin
            r_d.iset = '0;
            r_d.gap  = '0;
        end else if (r_q.gap != '0) begin
            r_d.gap = r_q.gap - 1'b1;
            if (r_q.gap == GW'(1)) begin
                r_d.iset = target;
            end
        end else if (target != r_q.iset) begin
            r_d.gap = GW'(GAP_CYC);
        end
    end

    assign iset   = r_q.iset;
    assign fet_ok = active && (r_q.gap == '0) && (target == r_q.iset);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/chg_cycle_ctrl.sv
`timescale 1ns/1ps
module chg_cycle_ctrl #(
    parameter int ICODE_W   = 8,
    parameter int PRESC_DIV = 250000,
    parameter int TMR_BASE  = 3600,
    parameter int GAP_CYC   = 250000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vin_ok,
    input  logic               hold_pin,
    input  logic               inhibit_bit,
    input  logic               bat_low,
    input  logic               cv_dom,
    input  logic               at_iterm,
    input  logic               lim_vin,
    input  logic               lim_path,
    input  logic               lim_therm,
    input  logic               zone_warm,
    input  logic               zone_cool,
    input  logic [ICODE_W-1:0] ifast_code,
    input  logic [ICODE_W-1:0] ipre_code,
    input  logic [1:0]         tmr_sel,
    input  logic               tmr_x2,
    output logic [2:0]         state_o,
    output logic [ICODE_W-1:0] iset_o,
    output logic               fet_on_o,
    output logic               tmr_fault_o
);
    import chg_pkg::*;

    fsm_regs_t r_q, r_d;
    logic charging, allow, any_lim, term_ok;
    logic pre_exp, fast_exp;
    logic [ICODE_W-1:0] target;

    always_comb begin
        charging = is_charging(r_q.state);
        allow    = !hold_pin && !inhibit_bit;                       // R1
        any_lim  = lim_vin || lim_path || lim_therm || zone_warm || zone_cool;
        term_ok  = at_iterm && cv_dom && !lim_vin && !lim_path
                   && !lim_therm && !zone_warm;                     // R5
        case (r_q.state)                                            // R3
            ST_PRE:  target = ipre_code;
            ST_FAST: target = (zone_warm || zone_cool) ? (ifast_code >> 1) : ifast_code;
            default: target = '0;
        endcase
    end

    chg_safety_timer #(
        .PRESC_DIV (PRESC_DIV),
        .TMR_BASE  (TMR_BASE)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (charging),
        .slow     (tmr_x2 && any_lim),
        .sel      (tmr_sel),
        .pre_exp  (pre_exp),
        .fast_exp (fast_exp)
    );

    chg_setpoint_gap #(
        .ICODE_W (ICODE_W),
        .GAP_CYC (GAP_CYC)
    ) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (charging),
        .target (target),
        .iset   (iset_o),
        .fet_ok (fet_on_o)
    );

    // Priority: input loss, fault hold, inhibit, then per-state progress
    always_comb begin
        r_d = r_q;
        if (!vin_ok) begin
            r_d.state = ST_OFF;                                     // R11
        end else if (r_q.state == ST_FAULT) begin
            r_d.state = hold_pin ? ST_OFF : ST_FAULT;               // R10
        end else if (!allow) begin
            r_d.state = ST_OFF;                                     // R1
        end else begin
            case (r_q.state)
                ST_OFF:  r_d.state = bat_low ? ST_PRE : ST_FAST;    // R2
                ST_PRE: begin
                    if (pre_exp)       r_d.state = ST_FAULT;        // R7
                    else if (!bat_low) r_d.state = ST_FAST;
                end
                ST_FAST: begin
                    if (fast_exp)      r_d.state = ST_FAULT;
                    else if (term_ok)  r_d.state = ST_DONE;
                end
                ST_DONE: r_d.state = ST_DONE;                       // R6
                default: r_d.state = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_OFF;                                    // R12
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o     = r_q.state;
    assign tmr_fault_o = (r_q.state == ST_FAULT);

endmodule

// File: rtl/chg_cycle_ctrl_chk.sv
`timescale 1ns/1ps
module chg_cycle_ctrl_chk #(
    parameter int ICODE_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               vin_ok,
    input logic               hold_pin,
    input logic               inhibit_bit,
    input logic               cv_dom,
    input logic               at_iterm,
    input logic               lim_vin,
    input logic               lim_path,
    input logic               lim_therm,
    input logic               zone_warm,
    input logic [2:0]         state_o,
    input logic [ICODE_W-1:0] iset_o,
    input logic               fet_on_o,
    input logic               tmr_fault_o
);
    AST_INHIBIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((hold_pin || inhibit_bit) && state_o != 3'd4) |=> state_o == 3'd0); // R1

    AST_GAP_BEFORE_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 3'd1 || state_o == 3'd2) && iset_o != $past(iset_o)) |-> !$past(fet_on_o)); // R4

    AST_TERM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && $past(state_o) == 3'd2) |->
        $past(at_iterm && cv_dom && !lim_vin && !lim_path && !lim_therm && !zone_warm)); // R5

    AST_DONE_FET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd3 |-> !fet_on_o); // R6

    AST_FAULT_FROM_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_fault_o && !$past(tmr_fault_o)) |-> ($past(state_o) == 3'd1 || $past(state_o) == 3'd2)); // R7

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && vin_ok && !hold_pin) |=> state_o == 3'd4); // R10

    AST_VIN_LOSS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !vin_ok |=> state_o == 3'd0); // R11

    AST_IDLE_ZERO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && $past(state_o) == 3'd0) |-> (iset_o == '0 && !fet_on_o)); // R3

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd4); // R12
endmodule

bind chg_cycle_ctrl chg_cycle_ctrl_chk #(.ICODE_W(ICODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vin_ok      (vin_ok),
    .hold_pin    (hold_pin),
    .inhibit_bit (inhibit_bit),
    .cv_dom      (cv_dom),
    .at_iterm    (at_iterm),
    .lim_vin     (lim_vin),
    .lim_path    (lim_path),
    .lim_therm   (lim_therm),
    .zone_warm   (zone_warm),
    .state_o     (state_o),
    .iset_o      (iset_o),
    .fet_on_o    (fet_on_o),
    .tmr_fault_o (tmr_fault_o)
);

// File: tb/chg_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module chg_cycle_ctrl_tb_top;
    localparam int W        = 8;
    localparam int TB_PRESC = 4;
    localparam int TB_BASE  = 16;
    localparam int TB_GAP   = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vin_ok = 0, hold_pin = 0, inhibit_bit = 0, bat_low = 0, cv_dom = 0, at_iterm = 0;
    logic lim_vin = 0, lim_path = 0, lim_therm = 0, zone_warm = 0, zone_cool = 0, tmr_x2 = 0;
    logic [W-1:0] ifast_code = 8'd200, ipre_code = 8'd20;
    logic [1:0] tmr_sel = 2'd3;
    logic [2:0] state_o;
    logic [W-1:0] iset_o;
    logic fet_on_o, tmr_fault_o;

    int checks = 0, fails = 0;
    string cur_req = "R12";
    bit finished = 0;

    always #2 clk = ~clk;

    chg_cycle_ctrl #(.ICODE_W(W), .PRESC_DIV(TB_PRESC), .TMR_BASE(TB_BASE), .GAP_CYC(TB_GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .vin_ok(vin_ok), .hold_pin(hold_pin), .inhibit_bit(inhibit_bit),
        .bat_low(bat_low), .cv_dom(cv_dom), .at_iterm(at_iterm), .lim_vin(lim_vin),
        .lim_path(lim_path), .lim_therm(lim_therm), .zone_warm(zone_warm), .zone_cool(zone_cool),
        .ifast_code(ifast_code), .ipre_code(ipre_code), .tmr_sel(tmr_sel), .tmr_x2(tmr_x2),
        .state_o(state_o), .iset_o(iset_o), .fet_on_o(fet_on_o), .tmr_fault_o(tmr_fault_o));

    // Behavioural reference model
    int m_st, m_iset, m_gap, m_presc, m_tcnt, m_half, m_sel;

    function automatic int m_target(int st);
        if (st == 1) return int'(ipre_code);
        if (st == 2) return (zone_warm || zone_cool) ? int'(ifast_code) / 2 : int'(ifast_code);
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_iset = 0; m_gap = 0; m_presc = 0; m_tcnt = 0; m_half = 0; m_sel = 0;
        end else begin
            int n_st, n_iset, n_gap, n_presc, n_tcnt, n_half, tgt, flim;
            bit chg, slow, term;
            chg  = (m_st == 1) || (m_st == 2);
            tgt  = m_target(m_st);
            flim = TB_BASE << tmr_sel;
            slow = tmr_x2 && (lim_vin || lim_path || lim_therm || zone_warm || zone_cool);
            term = at_iterm && cv_dom && !lim_vin && !lim_path && !lim_therm && !zone_warm;
            n_presc = m_presc; n_tcnt = m_tcnt; n_half = m_half;
            if (!chg || int'(tmr_sel) != m_sel) begin
                n_presc = 0; n_tcnt = 0; n_half = 0;
            end else if (m_presc == TB_PRESC - 1) begin
                n_presc = 0;
                if (slow) n_half = 1 - m_half;
                if (!slow || m_half == 1) n_tcnt = m_tcnt + 1;
            end else n_presc = m_presc + 1;
            n_iset = m_iset; n_gap = m_gap;
            if (!chg) begin n_iset = 0; n_gap = 0; end
            else if (m_gap != 0) begin n_gap = m_gap - 1; if (m_gap == 1) n_iset = tgt; end
            else if (tgt != m_iset) n_gap = TB_GAP;
            n_st = m_st;
            if (!vin_ok) n_st = 0;
            else if (m_st == 4) n_st = hold_pin ? 0 : 4;
            else if (hold_pin || inhibit_bit) n_st = 0;
            else if (m_st == 0) n_st = bat_low ? 1 : 2;
            else if (m_st == 1) n_st = (m_tcnt >= flim / 4) ? 4 : (!bat_low ? 2 : 1);
            else if (m_st == 2) n_st = (m_tcnt >= flim) ? 4 : (term ? 3 : 2);
            m_st = n_st; m_iset = n_iset; m_gap = n_gap; m_presc = n_presc;
            m_tcnt = n_tcnt; m_half = n_half; m_sel = int'(tmr_sel);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit e_fet;
            e_fet = ((m_st == 1) || (m_st == 2)) && m_gap == 0 && m_iset == m_target(m_st);
            checks++;
            if (int'(state_o) != m_st || int'(iset_o) != m_iset || fet_on_o != e_fet
                || tmr_fault_o != (m_st == 4)) begin
                fails++;
                $display("FAIL %s model compare: act st=%0d iset=%0d fet=%0d flt=%0d exp st=%0d iset=%0d fet=%0d flt=%0d",
                         cur_req, state_o, iset_o, fet_on_o, tmr_fault_o, m_st, m_iset, e_fet, m_st == 4);
            end
        end
    end

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        checks++; fails++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        cyc(3);
        chk("R12", int'(state_o), 0, "reset state");
        chk("R12", int'(iset_o), 0, "reset iset");
        chk("R12", int'(fet_on_o), 0, "reset fet");
        chk("R12", int'(tmr_fault_o), 0, "reset fault");
        rst_n = 1; vin_ok = 1; hold_pin = 1; bat_low = 1;
        cur_req = "R1";
        cyc(3); chk("R1", int'(state_o), 0, "pin high blocks");
        hold_pin = 0; inhibit_bit = 1;
        cyc(3); chk("R1", int'(state_o), 0, "bit set blocks");
        inhibit_bit = 0; cur_req = "R2";
        cyc(1); chk("R2", int'(state_o), 1, "enter pre");
        chk("R4", int'(fet_on_o), 0, "fet off on mismatch");
        cyc(3); chk("R4", int'(fet_on_o), 0, "fet off in gap");
        cyc(6); chk("R3", int'(iset_o), 20, "pre setpoint");
        chk("R4", int'(fet_on_o), 1, "fet on after gap");
        bat_low = 0;
        cyc(1); chk("R2", int'(state_o), 2, "pre to fast");
        cyc(10); chk("R3", int'(iset_o), 200, "fast setpoint");
        chk("R4", int'(fet_on_o), 1, "fet on fast");
        cur_req = "R3"; zone_cool = 1;
        cyc(1); chk("R4", int'(fet_on_o), 0, "zone change gap");
        chk("R4", int'(iset_o), 200, "old value in gap");
        cyc(10); chk("R3", int'(iset_o), 100, "cool halves");
        zone_cool = 0; cyc(10);
        cur_req = "R5"; at_iterm = 1;
        cyc(3); chk("R5", int'(state_o), 2, "no term without cv");
        cv_dom = 1; lim_vin = 1;
        cyc(3); chk("R5", int'(state_o), 2, "vin limit blocks term");
        lim_vin = 0; lim_path = 1;
        cyc(3); chk("R5", int'(state_o), 2, "path limit blocks term");
        lim_path = 0; lim_therm = 1;
        cyc(3); chk("R5", int'(state_o), 2, "thermal blocks term");
        lim_therm = 0; zone_warm = 1;
        cyc(3); chk("R5", int'(state_o), 2, "warm blocks term");
        zone_warm = 0;
        cyc(1); chk("R5", int'(state_o), 3, "terminate");
        cur_req = "R6";
        chk("R6", int'(fet_on_o), 0, "done fet off");
        cyc(10); chk("R6", int'(state_o), 3, "done holds");
        chk("R6", int'(fet_on_o), 0, "done fet stays off");
        cur_req = "R11"; vin_ok = 0;
        cyc(1); chk("R11", int'(state_o), 0, "vin loss off");
        cyc(1); chk("R11", int'(iset_o), 0, "setpoint cleared");
        at_iterm = 0; cv_dom = 0; vin_ok = 1; cur_req = "R2";
        cyc(1); chk("R2", int'(state_o), 2, "direct fast");
        cyc(10); chk("R4", int'(fet_on_o), 1, "fast fet");
        cur_req = "R4"; ifast_code = 8'd150;
        cyc(1); chk("R4", int'(fet_on_o), 0, "write gap");
        chk("R4", int'(iset_o), 200, "write old kept");
        cyc(10); chk("R4", int'(iset_o), 150, "write applied");
        cur_req = "R7"; tmr_sel = 2'd0;
        cyc(50); chk("R7", int'(state_o), 2, "before fast limit");
        cyc(30); chk("R7", int'(state_o), 4, "fast timeout");
        chk("R7", int'(tmr_fault_o), 1, "fault flag");
        chk("R7", int'(fet_on_o), 0, "fault fet off");
        cur_req = "R10"; inhibit_bit = 1;
        cyc(5); chk("R10", int'(state_o), 4, "bit does not clear");
        inhibit_bit = 0; hold_pin = 1;
        cyc(1); chk("R10", int'(state_o), 0, "pin clears fault");
        hold_pin = 0;
        cyc(1); chk("R10", int'(state_o), 2, "restart after clear");
        cur_req = "R7"; hold_pin = 1; bat_low = 1;
        cyc(2); hold_pin = 0;
        cyc(1); chk("R7", int'(state_o), 1, "pre again");
        cyc(10); chk("R7", int'(state_o), 1, "before pre limit");
        cyc(15); chk("R7", int'(state_o), 4, "pre timeout quarter");
        cur_req = "R10"; vin_ok = 0;
        cyc(1); chk("R10", int'(state_o), 0, "vin loss clears fault");
        cur_req = "R8"; vin_ok = 1; bat_low = 0; tmr_x2 = 1; lim_therm = 1;
        cyc(1); chk("R8", int'(state_o), 2, "fast for x2");
        cyc(100); chk("R8", int'(state_o), 2, "half rate extends");
        cyc(40); chk("R8", int'(state_o), 4, "half rate expires");
        vin_ok = 0; cyc(1);
        lim_therm = 0; tmr_x2 = 0; vin_ok = 1; cur_req = "R1";
        cyc(20); inhibit_bit = 1;
        cyc(1); chk("R1", int'(state_o), 0, "bit stops fast");
        inhibit_bit = 0;
        cyc(1); chk("R1", int'(state_o), 2, "resume");
        cur_req = "R9";
        cyc(50); tmr_sel = 2'd1;
        cyc(50); chk("R9", int'(state_o), 2, "restart on duration write");
        cyc(100); chk("R9", int'(state_o), 4, "new duration expires");
        cyc(2);
        finish_run();
    end
endmodule